// File: doc/BRIEF.md
# Reset Sequencer and Two-Level Vectored Interrupt Arbiter

This block sits next to a small CPU core and does two jobs. It merges three reset causes into one internal reset: power-on, an already-synchronized external pin request, and a watchdog timeout. After every cause has gone away it holds that reset for a start-up delay. The delay is measured by a binary start-up counter. A fuse input chooses whether the counter is tapped at a short stage or at a long stage. While the internal reset is active, the port pins are requested to float and the vector output reads address zero, so the core restarts from the bottom of program memory.

Outside reset, the block arbitrates a set of pending-flag interrupt requests. By default there are two: external interrupt 0 and timer 0 overflow. A request is only considered at an instruction boundary. It must have both its own enable and the global enable set. The lowest-indexed request wins, and request i is sent to vector address i+1. When a request is accepted, the block issues a single-cycle take pulse, which the core uses to clear its global enable. In the same cycle it issues the vector and a one-hot clear strobe for the winning flag. All interfaces are plain level or strobe signals with no back-pressure. The core has to load the vector in the cycle the take pulse is high.

Top module: `bootirq_ctrl`

## Requirements
- R1: `sys_rst` is 1 in every cycle in which `por_req`, `ext_rst_req` or `wdt_expire` is 1, with no clock edge needed.
- R2: Once all three reset causes are 0, `sys_rst` stays 1 for exactly 2^SHORT_TAP rising edges when `fuse_long`=0, or 2^LONG_TAP rising edges when `fuse_long`=1. It falls after the last of those edges. The defaults are taps 10 and 13.
- R3: If any reset cause is seen at a rising edge while the start-up delay is counting, the count restarts. The full delay is then measured again from the final release.
- R4: While `sys_rst` is 1, `pins_hiz` is 1, `vec_addr` is 0, `irq_take` is 0 and `flag_clr` is all zeros, whatever the interrupt inputs are.
- R5: At a rising edge with `insn_boundary`=1, `gie`=1 and at least one i where `irq_flag[i]` and `irq_en[i]` are both 1, `irq_take` goes to 1 for the following cycle.
- R6: When several requests are eligible at the same edge, the one with the lowest index is taken. Bit 0 is external interrupt 0 and bit 1 is timer 0 overflow.
- R7: The vector issued for request index i is i+1. Vector 1 is external interrupt 0 and vector 2 is timer overflow. Vector 0 is reserved for reset.
- R8: `irq_take` lasts exactly one cycle and is never high in two cycles back to back. While it is high, `flag_clr` has exactly one bit set, the bit of the taken request. Otherwise `flag_clr` is zero.
- R9: No request is taken when `insn_boundary`=0, when `gie`=0, or when no flag has its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_req | input | 1 | Power-on reset cause, active high, also asynchronous clear of the sequencer |
| ext_rst_req | input | 1 | Synchronized external reset cause, active high |
| wdt_expire | input | 1 | Watchdog timeout cause, active high |
| fuse_long | input | 1 | Start-up length select: 0 short tap, 1 long tap |
| irq_flag | input | N_IRQ | Pending flags, bit 0 highest priority |
| irq_en | input | N_IRQ | Per-request enables |
| gie | input | 1 | Global interrupt enable |
| insn_boundary | input | 1 | High in cycles where an interrupt may be accepted |
| sys_rst | output | 1 | Internal reset, active high |
| pins_hiz | output | 1 | Request to float the port pins |
| vec_addr | output | VEC_W | Vector address; 0 in reset, valid with irq_take |
| irq_take | output | 1 | One-cycle accept pulse; the core clears its global enable on it |
| flag_clr | output | N_IRQ | One-hot clear strobe for the taken flag |

## Verification
The checker verifies in every cycle that any active reset cause forces the internal reset, and that reset silences the pins, the vector, the take pulse and the clear strobes. It also verifies that each take follows an eligible boundary request, that it is a lone one-cycle pulse with a one-hot clear, and that vector 2 is never chosen over an eligible request 0. The exact length of the start-up delay under each fuse setting, and the restart of the delay by a cause arriving mid-count, are shown only by the bench's directed scenarios. The same applies to the full mapping from request patterns to vectors.

// File: rtl/bootirq_pkg.sv
package bootirq_pkg;
  localparam int unsigned RESET_VECTOR = 0;
  localparam int unsigned VEC_BASE     = 1;
endpackage

// File: rtl/rst_seq.sv
module rst_seq #(
  parameter int unsigned SHORT_TAP = 10,
  parameter int unsigned LONG_TAP  = 13
) (
  input  logic clk,
  input  logic por_req,
  input  logic ext_rst_req,
  input  logic wdt_expire,
  input  logic fuse_long,
  output logic rst_out
);
  localparam int unsigned CNT_W = LONG_TAP + 1;

  logic             any_src;
  logic             hold_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             tap_hit;

  assign any_src = por_req | ext_rst_req | wdt_expire;
  assign cnt_nxt = cnt_q + CNT_W'(1);
  assign tap_hit = fuse_long ? cnt_nxt[LONG_TAP] : cnt_nxt[SHORT_TAP];

  // The power-on cause clears asynchronously; the other causes act at the clock edge.
  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (ext_rst_req | wdt_expire) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_q) begin
      cnt_q <= cnt_nxt;
      if (tap_hit) hold_q <= 1'b0;
    end
  end

  assign rst_out = any_src | hold_q;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import bootirq_pkg::*;
#(
  parameter int unsigned N_IRQ = 2,
  parameter int unsigned VEC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             gie,
  input  logic             insn_boundary,
  output logic             take_q,
  output logic [VEC_W-1:0] vec_q,
  output logic [N_IRQ-1:0] clr_q
);
  localparam int unsigned IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  logic [N_IRQ-1:0] req;
  logic [IDX_W-1:0] win_idx;
  logic             any_req;
  logic             accept;

  assign req     = irq_flag & irq_en;
  assign any_req = |req;

  // Scanning from the top index down leaves the lowest active index as the winner.
  always_comb begin
    win_idx = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (req[i]) win_idx = IDX_W'(i);
    end
  end

  // No accept in the cycle right after a take, so the core has time to drop gie.
  assign accept = insn_boundary & gie & any_req & ~take_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b0;
      vec_q  <= VEC_W'(RESET_VECTOR);
      clr_q  <= '0;
    end else begin
      take_q <= accept;
      clr_q  <= accept ? (N_IRQ'(1) << win_idx) : '0;
      if (accept) vec_q <= VEC_W'(win_idx) + VEC_W'(VEC_BASE);
    end
  end
endmodule

// File: rtl/bootirq_ctrl.sv
module bootirq_ctrl
  import bootirq_pkg::*;
#(
  parameter int unsigned N_IRQ     = 2,
  parameter int unsigned VEC_W     = 10,
  parameter int unsigned SHORT_TAP = 10,
  parameter int unsigned LONG_TAP  = 13
) (
  input  logic             clk,
  input  logic             por_req,
  input  logic             ext_rst_req,
  input  logic             wdt_expire,
  input  logic             fuse_long,
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             gie,
  input  logic             insn_boundary,
  output logic             sys_rst,
  output logic             pins_hiz,
  output logic [VEC_W-1:0] vec_addr,
  output logic             irq_take,
  output logic [N_IRQ-1:0] flag_clr
);
  logic             rst_int;
  logic             take_q;
  logic [VEC_W-1:0] vec_q;
  logic [N_IRQ-1:0] clr_q;

  rst_seq #(.SHORT_TAP(SHORT_TAP), .LONG_TAP(LONG_TAP)) u_rst (
    .clk(clk), .por_req(por_req), .ext_rst_req(ext_rst_req),
    .wdt_expire(wdt_expire), .fuse_long(fuse_long), .rst_out(rst_int)
  );

  irq_arb #(.N_IRQ(N_IRQ), .VEC_W(VEC_W)) u_arb (
    .clk(clk), .rst(rst_int), .irq_flag(irq_flag), .irq_en(irq_en),
    .gie(gie), .insn_boundary(insn_boundary),
    .take_q(take_q), .vec_q(vec_q), .clr_q(clr_q)
  );

  assign sys_rst  = rst_int;
  assign pins_hiz = rst_int;
  assign vec_addr = rst_int ? VEC_W'(RESET_VECTOR) : vec_q;
  assign irq_take = take_q & ~rst_int;
  assign flag_clr = rst_int ? '0 : clr_q;
endmodule

// File: rtl/bootirq_ctrl_chk.sv
module bootirq_ctrl_chk #(
  parameter int unsigned N_IRQ = 2,
  parameter int unsigned VEC_W = 10
) (
  input logic             clk,
  input logic             por_req,
  input logic             ext_rst_req,
  input logic             wdt_expire,
  input logic [N_IRQ-1:0] irq_flag,
  input logic [N_IRQ-1:0] irq_en,
  input logic             gie,
  input logic             insn_boundary,
  input logic             sys_rst,
  input logic             pins_hiz,
  input logic [VEC_W-1:0] vec_addr,
  input logic             irq_take,
  input logic [N_IRQ-1:0] flag_clr
);
  // R1
  src_forces_rst_chk: assert property (@(posedge clk) disable iff (por_req)
    (ext_rst_req || wdt_expire) |-> sys_rst);

  // R4
  rst_quiet_chk: assert property (@(posedge clk) disable iff (por_req)
    sys_rst |-> (pins_hiz && vec_addr == '0 && !irq_take && flag_clr == '0));

  // R5
  take_cause_chk: assert property (@(posedge clk) disable iff (sys_rst)
    irq_take |-> $past(insn_boundary && gie && ((irq_flag & irq_en) != '0)));

  // R8
  take_single_chk: assert property (@(posedge clk) disable iff (sys_rst)
    irq_take |=> !irq_take);

  // R8
  clr_onehot_chk: assert property (@(posedge clk) disable iff (sys_rst)
    irq_take |-> ($countones(flag_clr) == 1));

  // R8
  clr_idle_chk: assert property (@(posedge clk) disable iff (sys_rst)
    !irq_take |-> (flag_clr == '0));

  // R6
  prio_chk: assert property (@(posedge clk) disable iff (sys_rst)
    (irq_take && vec_addr == VEC_W'(2)) |-> !$past(irq_flag[0] && irq_en[0]));
endmodule

bind bootirq_ctrl bootirq_ctrl_chk #(.N_IRQ(N_IRQ), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .por_req(por_req), .ext_rst_req(ext_rst_req), .wdt_expire(wdt_expire),
  .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie), .insn_boundary(insn_boundary),
  .sys_rst(sys_rst), .pins_hiz(pins_hiz), .vec_addr(vec_addr),
  .irq_take(irq_take), .flag_clr(flag_clr)
);

// File: tb/bootirq_ctrl_tb.sv
module bootirq_ctrl_tb;
  localparam int unsigned N_IRQ = 2;
  localparam int unsigned VEC_W = 10;
  localparam int unsigned STAP  = 3;
  localparam int unsigned LTAP  = 5;
  localparam int unsigned NVEC  = 9;

  // Entry layout: flag[10:9] en[8:7] gie[6] bnd[5] take[4] vec[3:2] clr[1:0]
  localparam logic [10:0] TBL [NVEC] = '{
    11'b11_11_1_1_1_01_01,
    11'b10_11_1_1_1_10_10,
    11'b01_11_1_1_1_01_01,
    11'b11_10_1_1_1_10_10,
    11'b11_11_0_1_0_00_00,
    11'b11_11_1_0_0_00_00,
    11'b11_00_1_1_0_00_00,
    11'b00_11_1_1_0_00_00,
    11'b01_10_1_1_0_00_00
  };

  logic clk = 1'b0;
  logic por_req, ext_rst_req, wdt_expire, fuse_long, gie, insn_boundary;
  logic [N_IRQ-1:0] irq_flag, irq_en;
  logic sys_rst, pins_hiz, irq_take;
  logic [VEC_W-1:0] vec_addr;
  logic [N_IRQ-1:0] flag_clr;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bootirq_ctrl #(.N_IRQ(N_IRQ), .VEC_W(VEC_W), .SHORT_TAP(STAP), .LONG_TAP(LTAP)) u_dut (
    .clk(clk), .por_req(por_req), .ext_rst_req(ext_rst_req), .wdt_expire(wdt_expire),
    .fuse_long(fuse_long), .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie),
    .insn_boundary(insn_boundary), .sys_rst(sys_rst), .pins_hiz(pins_hiz),
    .vec_addr(vec_addr), .irq_take(irq_take), .flag_clr(flag_clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic quiet_irq();
    irq_flag = '0; irq_en = '0; gie = 1'b0; insn_boundary = 1'b0;
  endtask

  // Counts start-up edges after a release at a falling edge.
  task automatic count_release(input string req, input int unsigned edges);
    repeat (edges - 1) @(negedge clk);
    chk({req, " still held"}, 32'(sys_rst), 32'd1);
    @(negedge clk);
    chk({req, " released"}, 32'(sys_rst), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    por_req = 1'b1; ext_rst_req = 1'b0; wdt_expire = 1'b0; fuse_long = 1'b0;
    irq_flag = 2'b11; irq_en = 2'b11; gie = 1'b1; insn_boundary = 1'b1;
    repeat (2) @(negedge clk);
    // R4 reset state, requests active but silenced
    chk("R4 pins_hiz", 32'(pins_hiz), 32'd1);
    chk("R4 vec", 32'(vec_addr), 32'd0);
    chk("R4 take", 32'(irq_take), 32'd0);
    chk("R4 clr", 32'(flag_clr), 32'd0);
    chk("R1 por", 32'(sys_rst), 32'd1);
    quiet_irq();
    por_req = 1'b0;
    count_release("R2 short", 1 << STAP);

    // R1 immediate assertion by a cause, without an edge
    ext_rst_req = 1'b1;
    #1;
    chk("R1 ext", 32'(sys_rst), 32'd1);
    @(negedge clk);
    ext_rst_req = 1'b0;
    repeat (4) @(negedge clk);
    // R3 restart mid-count by watchdog
    wdt_expire = 1'b1;
    #1;
    chk("R1 wdt", 32'(sys_rst), 32'd1);
    @(negedge clk);
    wdt_expire = 1'b0;
    count_release("R3 restart", 1 << STAP);

    // R2 long tap
    fuse_long = 1'b1;
    ext_rst_req = 1'b1;
    @(negedge clk);
    ext_rst_req = 1'b0;
    count_release("R2 long", 1 << LTAP);
    fuse_long = 1'b0;

    // R5 R6 R7 R9 vector table
    for (int k = 0; k < NVEC; k++) begin
      irq_flag = TBL[k][10:9]; irq_en = TBL[k][8:7];
      gie = TBL[k][6]; insn_boundary = TBL[k][5];
      @(negedge clk);
      chk($sformatf("R5/R9 take row %0d", k), 32'(irq_take), 32'(TBL[k][4]));
      chk($sformatf("R8 clr row %0d", k), 32'(flag_clr), 32'(TBL[k][1:0]));
      if (TBL[k][4]) chk($sformatf("R6/R7 vec row %0d", k), 32'(vec_addr), 32'(TBL[k][3:2]));
      quiet_irq();
      @(negedge clk);
    end

    // R8 boundary held with gie still 1: single pulse, gap cycle
    irq_flag = 2'b10; irq_en = 2'b11; gie = 1'b1; insn_boundary = 1'b1;
    @(negedge clk);
    chk("R8 first take", 32'(irq_take), 32'd1);
    chk("R7 timer vec", 32'(vec_addr), 32'd2);
    @(negedge clk);
    chk("R8 no back-to-back", 32'(irq_take), 32'd0);
    chk("R8 clr idle", 32'(flag_clr), 32'd0);
    quiet_irq();
    @(negedge clk);

    // R4 reset while requests eligible
    irq_flag = 2'b01; irq_en = 2'b01; gie = 1'b1; insn_boundary = 1'b1;
    ext_rst_req = 1'b1;
    @(negedge clk);
    chk("R4 take in reset", 32'(irq_take), 32'd0);
    chk("R4 vec in reset", 32'(vec_addr), 32'd0);
    chk("R4 hiz in reset", 32'(pins_hiz), 32'd1);
    ext_rst_req = 1'b0;
    quiet_irq();
    count_release("R2 after ext", 1 << STAP);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule